// File: doc/BRIEF.md
# UART Modem and Flow-Control Unit

This block holds the modem-control fields of a UART control word and turns them into pin and permit signals for the serial link. Software writes and reads a 16-bit control word through a plain register port. From the transmitter the block receives an idle flag and a request to start a character. From the receiver it receives a character-in-progress flag. From the receive FIFO it receives a count of free entries.

It drives the active-low request-to-send and data-terminal-ready pins. It also drives a start permit for the transmitter and an effective receive enable for the receiver. Transmission can be gated by a synchronised clear-to-send input. Request-to-send can be driven by software or from FIFO free space. Turning the receiver off takes effect only between characters.

All pins and status lines are level signals with no handshake. A control-word write is a single-cycle strobe that always completes.

Top module: `uart_modem_ctl`

## Requirements
- R1: After reset the control word reads 0x0200, `rts_n_out` and `dtr_n_out` are 1, and `rx_en_eff` equals `uart_en`.
- R2: Bits 13:12 and 8:0 of the control word always read 0, and writing ones to them has no effect.
- R3: The control fields are CTS gating at bit 15, automatic RTS at bit 14, software RTS at bit 11, DTR at bit 10 and receive enable at bit 9. A write strobed on one rising edge is visible on `reg_rd_data` right after that edge.
- R4: `tx_start_ok` is high only when `tx_start_req` and `tx_idle` are both high and either CTS gating is 0 or the synchronised CTS is asserted (input low). The CTS input passes two flops, so a change reaches `tx_start_ok` after the second rising edge.
- R5: With automatic RTS at 1, `rts_n_out` is 0 when `fifo_free` was non-zero on the previous rising edge, and 1 when it was zero. The pin is registered, one cycle behind.
- R6: With automatic RTS at 0, `rts_n_out` is the inverse of the software RTS bit, one cycle behind. While the stored automatic RTS bit is 1, a write does not change the software RTS bit, and bit 11 reads as 0.
- R7: `dtr_n_out` is the inverse of the stored DTR bit and changes right after the write edge.
- R8: When receive enable is cleared while `rx_busy` is high, the internal receive-run state stays on until a rising edge sees `rx_busy` low. Setting receive enable turns the run state on at the next edge.
- R9: `rx_en_eff` is high only when the receive-run state is on and `uart_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Control-word write strobe |
| reg_wr_data | input | 16 | Control-word write data |
| reg_rd_data | output | 16 | Control-word read value |
| uart_en | input | 1 | Global UART enable |
| tx_idle | input | 1 | Transmitter is between characters |
| tx_start_req | input | 1 | Transmitter wants to start a character |
| rx_busy | input | 1 | Receiver is inside a character |
| fifo_free | input | FREE_W | Free entries in the receive FIFO |
| cts_n_in | input | 1 | Clear-to-send pin, active low, asynchronous |
| rts_n_out | output | 1 | Request-to-send pin, active low |
| dtr_n_out | output | 1 | Data-terminal-ready pin, active low |
| tx_start_ok | output | 1 | Permit for the transmitter to begin a character |
| rx_en_eff | output | 1 | Effective receive enable |

## Verification
The assertions assume that every input is a known level from the first rising edge after reset. They also assume that `fifo_free` is sampled as a plain count and not as a handshake. The graceful-stop check further assumes that `rx_busy` falls at some point; otherwise the receive-run state is held on indefinitely by design. The stimulus changes all inputs one time unit after a rising edge and drives every line from time zero. Its random phase drops `rx_busy` often, so each disable request reaches a character boundary within a few cycles.

// File: rtl/mfc_pkg.sv
package mfc_pkg;
  localparam int CTRL_W    = 16;
  localparam int POS_CTSEN = 15;
  localparam int POS_RTSEN = 14;
  localparam int POS_RTS   = 11;
  localparam int POS_DTR   = 10;
  localparam int POS_RXE   = 9;

  typedef struct packed {
    logic cts_en;
    logic rts_auto;
    logic rts_sw;
    logic dtr;
    logic rxe;
  } mfc_ctrl_t;

  localparam mfc_ctrl_t CTRL_RESET = '{cts_en: 1'b0, rts_auto: 1'b0,
                                      rts_sw: 1'b0, dtr: 1'b0, rxe: 1'b1};
endpackage

// File: rtl/mfc_ctrl_reg.sv
module mfc_ctrl_reg
  import mfc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output mfc_ctrl_t         ctrl,
  output logic [CTRL_W-1:0] rd_data
);
  mfc_ctrl_t ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RESET;
    end else if (wr_en) begin
      ctrl_q.cts_en   <= wr_data[POS_CTSEN];
      ctrl_q.rts_auto <= wr_data[POS_RTSEN];
      ctrl_q.dtr      <= wr_data[POS_DTR];
      ctrl_q.rxe      <= wr_data[POS_RXE];
      if (!ctrl_q.rts_auto) ctrl_q.rts_sw <= wr_data[POS_RTS];
    end
  end

  always_comb begin
    rd_data            = '0;
    rd_data[POS_CTSEN] = ctrl_q.cts_en;
    rd_data[POS_RTSEN] = ctrl_q.rts_auto;
    rd_data[POS_RTS]   = ctrl_q.rts_sw & ~ctrl_q.rts_auto;
    rd_data[POS_DTR]   = ctrl_q.dtr;
    rd_data[POS_RXE]   = ctrl_q.rxe;
  end

  assign ctrl = ctrl_q;

  assert_wr_visible_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en) |-> (rd_data[POS_CTSEN] == $past(wr_data[POS_CTSEN])) &&
                     (rd_data[POS_RXE] == $past(wr_data[POS_RXE])));

  assert_rts_rd_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.rts_auto |-> !rd_data[POS_RTS]);

  assert_sw_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctrl_q.rts_auto) |-> $stable(ctrl_q.rts_sw));
endmodule

// File: rtl/mfc_cts_sync.sv
module mfc_cts_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cts_n_in,
  output logic cts_asserted
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= 1'b1;
        else if (s == 0) chain_q[s] <= cts_n_in;
        else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign cts_asserted = ~chain_q[STAGES-1];
endmodule

// File: rtl/mfc_rts_gen.sv
module mfc_rts_gen #(
  parameter int FREE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              auto_en,
  input  logic              sw_rts,
  input  logic [FREE_W-1:0] fifo_free,
  output logic              rts_n_out
);
  logic space_avail;
  logic rts_n_q;

  assign space_avail = |fifo_free;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rts_n_q <= 1'b1;
    else        rts_n_q <= auto_en ? ~space_avail : ~sw_rts;
  end

  assign rts_n_out = rts_n_q;

  assert_rts_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(auto_en) && ($past(fifo_free) == '0)) |-> rts_n_out);
endmodule

// File: rtl/mfc_rx_gate.sv
module mfc_rx_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic rxe,
  input  logic rx_busy,
  input  logic uart_en,
  output logic rx_en_eff
);
  logic run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b1;
    else        run_q <= rxe | (run_q & rx_busy);
  end

  assign rx_en_eff = run_q & uart_en;

  assert_rx_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run_q) && $past(rx_busy)) |-> run_q);

  assert_rx_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en_eff |-> uart_en);
endmodule

// File: rtl/uart_modem_ctl.sv
module uart_modem_ctl
  import mfc_pkg::*;
#(
  parameter int FREE_W = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [15:0]       reg_wr_data,
  output logic [15:0]       reg_rd_data,
  input  logic              uart_en,
  input  logic              tx_idle,
  input  logic              tx_start_req,
  input  logic              rx_busy,
  input  logic [FREE_W-1:0] fifo_free,
  input  logic              cts_n_in,
  output logic              rts_n_out,
  output logic              dtr_n_out,
  output logic              tx_start_ok,
  output logic              rx_en_eff
);
  mfc_ctrl_t ctrl;
  logic      cts_asserted;

  mfc_ctrl_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wr_data(reg_wr_data),
    .ctrl(ctrl), .rd_data(reg_rd_data)
  );

  mfc_cts_sync #(.STAGES(SYNC_STAGES)) u_cts (
    .clk(clk), .rst_n(rst_n), .cts_n_in(cts_n_in), .cts_asserted(cts_asserted)
  );

  mfc_rts_gen #(.FREE_W(FREE_W)) u_rts (
    .clk(clk), .rst_n(rst_n), .auto_en(ctrl.rts_auto), .sw_rts(ctrl.rts_sw),
    .fifo_free(fifo_free), .rts_n_out(rts_n_out)
  );

  mfc_rx_gate u_rx (
    .clk(clk), .rst_n(rst_n), .rxe(ctrl.rxe), .rx_busy(rx_busy),
    .uart_en(uart_en), .rx_en_eff(rx_en_eff)
  );

  assign dtr_n_out   = ~ctrl.dtr;
  assign tx_start_ok = tx_start_req & tx_idle & (~ctrl.cts_en | cts_asserted);

  assert_tx_permit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start_ok |-> (tx_start_req && tx_idle));

  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_wr_en) |-> (reg_rd_data[13:12] == 2'b00) && (reg_rd_data[8:0] == '0));
endmodule

// File: tb/uart_modem_ctl_tb.sv
module uart_modem_ctl_tb_top;
  localparam int FREE_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr_en = 1'b0;
  logic [15:0] reg_wr_data = '0;
  logic [15:0] reg_rd_data;
  logic uart_en = 1'b1, tx_idle = 1'b0, tx_start_req = 1'b0, rx_busy = 1'b0;
  logic [FREE_W-1:0] fifo_free = '0;
  logic cts_n_in = 1'b1;
  logic rts_n_out, dtr_n_out, tx_start_ok, rx_en_eff;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  uart_modem_ctl #(.FREE_W(FREE_W)) dut_i (.*);

  // behavioural reference model
  bit m_cts_en, m_auto, m_sw, m_dtr, m_rxe, m_rts_n, m_run;
  bit cts_hist[$];

  task automatic model_reset();
    m_cts_en = 0; m_auto = 0; m_sw = 0; m_dtr = 0; m_rxe = 1;
    m_rts_n = 1; m_run = 1;
    cts_hist = {1'b1, 1'b1};
  endtask

  initial model_reset();

  always @(posedge clk) if (rst_n) begin
    bit n_rts_n, n_run;
    n_rts_n = m_auto ? (fifo_free == 0) : !m_sw;
    n_run   = m_rxe || (m_run && rx_busy);
    cts_hist.push_back(cts_n_in);
    void'(cts_hist.pop_front());
    if (reg_wr_en) begin
      if (!m_auto) m_sw = reg_wr_data[11];
      m_cts_en = reg_wr_data[15]; m_auto = reg_wr_data[14];
      m_dtr = reg_wr_data[10];    m_rxe = reg_wr_data[9];
    end
    m_rts_n = n_rts_n;
    m_run = n_run;
  end

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    logic [15:0] e_rd;
    cycles++;
    e_rd = '0;
    e_rd[15] = m_cts_en; e_rd[14] = m_auto; e_rd[11] = m_sw && !m_auto;
    e_rd[10] = m_dtr;    e_rd[9]  = m_rxe;
    check("R3 control word", reg_rd_data, e_rd);
    check("R4 start permit", {15'b0, tx_start_ok},
          {15'b0, tx_start_req && tx_idle && (!m_cts_en || cts_hist[0] == 1'b0)});
    check(m_auto ? "R5 auto rts" : "R6 manual rts", {15'b0, rts_n_out}, {15'b0, m_rts_n});
    check("R7 dtr pin", {15'b0, dtr_n_out}, {15'b0, !m_dtr});
    check("R8 R9 rx enable", {15'b0, rx_en_eff}, {15'b0, m_run && uart_en});
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic write_ctrl(logic [15:0] d);
    reg_wr_en = 1; reg_wr_data = d; tick(); reg_wr_en = 0; reg_wr_data = '0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    tick(3000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    #20;
    check("R1 reset word", reg_rd_data, 16'h0200);
    check("R1 reset pins", {14'b0, rts_n_out, dtr_n_out}, 16'h0003);
    check("R1 reset rx", {15'b0, rx_en_eff}, 16'h0001);
    @(negedge clk); rst_n = 1;
    tick();
    // DTR and manual RTS
    write_ctrl(16'h0600); tick(2);
    write_ctrl(16'h0A00); tick(2);
    // reserved bits, switch to auto
    write_ctrl(16'hFFFF);
    @(negedge clk); check("R2 reserved bits", reg_rd_data & 16'h31FF, 16'h0000);
    tick();
    fifo_free = 0; tick(2);
    @(negedge clk); check("R5 fifo full", {15'b0, rts_n_out}, 16'h0001);
    tick(); fifo_free = 3; tick(2);
    @(negedge clk); check("R5 fifo space", {15'b0, rts_n_out}, 16'h0000);
    tick();
    // software RTS write discarded in auto mode, then back to manual
    write_ctrl(16'h4200);
    write_ctrl(16'h0200); tick();
    @(negedge clk); check("R6 sw rts kept", {15'b0, rts_n_out}, 16'h0000);
    tick();
    // CTS gating
    write_ctrl(16'h8200); tx_idle = 1; tx_start_req = 1;
    cts_n_in = 1; tick(3); cts_n_in = 0; tick(1);
    @(negedge clk); check("R4 cts after one edge", {15'b0, tx_start_ok}, 16'h0000);
    tick(1);
    @(negedge clk); check("R4 cts after two edges", {15'b0, tx_start_ok}, 16'h0001);
    tick(); cts_n_in = 1; tick(3);
    // graceful receive stop
    rx_busy = 1; write_ctrl(16'h0000); tick(3);
    @(negedge clk); check("R8 hold while busy", {15'b0, rx_en_eff}, 16'h0001);
    tick(); rx_busy = 0; tick();
    @(negedge clk); check("R8 stop at boundary", {15'b0, rx_en_eff}, 16'h0000);
    tick(); write_ctrl(16'h0200); uart_en = 0; tick();
    @(negedge clk); check("R9 uart disabled", {15'b0, rx_en_eff}, 16'h0000);
    tick(); uart_en = 1;
    // random phase
    for (int i = 0; i < 1500; i++) begin
      logic [15:0] rw;
      rw = 16'($urandom);
      reg_wr_en = ($urandom_range(0, 7) == 0);
      reg_wr_data = rw;
      uart_en = ($urandom_range(0, 5) != 0);
      tx_idle = $urandom_range(0, 1);
      tx_start_req = $urandom_range(0, 1);
      rx_busy = ($urandom_range(0, 2) == 0);
      fifo_free = ($urandom_range(0, 2) == 0) ? '0 : FREE_W'($urandom);
      cts_n_in = $urandom_range(0, 1);
      tick();
    end
    reg_wr_en = 0; tick(2);
    @(negedge clk);
    finish_run();
  end
endmodule